// File: doc/BRIEF.md
# Key-Enabled Configuration Window Decoder

This block turns an I/O space into a legacy configuration access path. It has two byte registers. The enable register sits at I/O port 0xCF8. Its upper nibble is a key and bits 3:1 select a PCI function number. The forward register sits at I/O port 0xCFA and holds the target bus number. When the key holds 0xF, the 4 KB I/O page 0xC000–0xCFFF stops being ordinary I/O and acts as configuration space. Inside that page, address bits 11:8 pick one of sixteen devices and bits 7:0 pick the register offset.

Each aligned access inside the mapped page produces one configuration request. The request carries the bus, device, function, dword index, byte enables and lane-placed write data. The I/O cycle stalls until the downstream side acknowledges. Any access this block does not claim completes in the same cycle: reads return all ones and writes are dropped. Software turns the window off by writing zero to the enable register.

I/O accesses use a hold-until-ready handshake. `io_len` selects the access size: 0 is byte, 1 is 16-bit, 2 is 32-bit, and 3 is never claimed. Data on the I/O side is right-justified.

Top module: `cfg2_window_decoder`

## Requirements
- R1: After reset, the enable register and the forward register both read back as 0x00, and no configuration request is active.
- R2: A byte write to port 0xCF8 or port 0xCFA stores all eight bits, including enable bit 0. A byte read of either port returns the stored value in bits 7:0, with bits 31:8 at zero. Enable bit 0 has no effect on decoding.
- R3: The window 0xC000–0xCFFF is mapped only while enable bits 7:4 equal 0xF.
- R4: A mapped access drives the request fields as follows: `cfg_dev` = address bits 11:8 (only 16 devices are reachable), `cfg_dw` = address bits 7:2, `cfg_fn` = enable bits 3:1, and `cfg_bus` = the forward register.
- R5: A mapped access must be aligned. A byte access may be at any address. A 16-bit access needs address bit 0 = 0. A 32-bit access needs address bits 1:0 = 0. Byte enables are 0001 shifted left by address bits 1:0 for a byte access, 0011 shifted left by address bits 1:0 for a 16-bit access, and 1111 for a 32-bit access. Write data is shifted left by 8 × address bits 1:0.
- R6: Read data for a mapped access is `cfg_rdata` shifted right by 8 × address bits 1:0. Bytes above the access size are returned as zero.
- R7: `cfg_req` rises in the cycle after a mapped access is presented. It stays high, with stable fields, until `cfg_ack`. `io_ready` stays low until the `cfg_ack` cycle and rises in that cycle.
- R8: An unclaimed access completes with `io_ready` in the same cycle and issues no request. A read returns 0xFFFFFFFF and a write has no effect. Unclaimed accesses are: any window access while the key is not 0xF, a misaligned window access, any access with size code 3, and any other address except a byte access to the two registers.
- R9: After 0x00 is written to both registers, both read back as 0x00 and the window is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O access present; held until io_ready |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_len | input | 2 | Size: 0 byte, 1 16-bit, 2 32-bit |
| io_wdata | input | 32 | Right-justified write data |
| io_ready | output | 1 | Access completes this cycle |
| io_rdata | output | 32 | Right-justified read data, valid with io_ready |
| cfg_req | output | 1 | Configuration request pending |
| cfg_wr | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 4 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_dw | output | 6 | Dword index within the 256-byte space |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_ack | input | 1 | Request completes this cycle |
| cfg_rdata | input | 32 | Lane-placed read data, valid with cfg_ack |

## Verification
The assertions assume the I/O master holds `io_req` and its fields steady until it sees `io_ready`, and then drops the access. They also assume `cfg_ack` arrives only while `cfg_req` is high. The bench drives every access from a single task that keeps these rules. That task raises `cfg_ack` only after it has seen the request held for at least one stall cycle. It lowers `io_req` and `cfg_ack` together on the falling edge that follows completion.

// File: rtl/cfg2_window_decoder.sv
module cfg2_window_decoder #(
  parameter logic [15:0] EN_PORT  = 16'h0CF8,
  parameter logic [15:0] FWD_PORT = 16'h0CFA,
  parameter logic [3:0]  WIN_PAGE = 4'hC,
  parameter logic [3:0]  KEY      = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [1:0]  io_len,
  input  logic [31:0] io_wdata,
  output logic        io_ready,
  output logic [31:0] io_rdata,
  output logic        cfg_req,
  output logic        cfg_wr,
  output logic [7:0]  cfg_bus,
  output logic [3:0]  cfg_dev,
  output logic [2:0]  cfg_fn,
  output logic [5:0]  cfg_dw,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata
);

  logic [7:0]  en_q, fwd_q;
  logic        busy_q;
  logic [1:0]  off_q, len_q;
  logic [3:0]  be_n;
  logic [31:0] rd_shift, rd_masked;

  wire map_on   = (en_q[7:4] == KEY);
  wire aligned  = (io_len == 2'd0) ||
                  (io_len == 2'd1 && !io_addr[0]) ||
                  (io_len == 2'd2 && io_addr[1:0] == 2'b00);
  wire in_win   = map_on && (io_addr[15:12] == WIN_PAGE) && aligned;
  wire en_hit   = (io_addr == EN_PORT)  && (io_len == 2'd0);
  wire fwd_hit  = (io_addr == FWD_PORT) && (io_len == 2'd0);
  wire start    = io_req && !busy_q && in_win;
  wire local_dn = io_req && !busy_q && !in_win;

  assign io_ready = local_dn || (busy_q && cfg_ack);
  assign cfg_req  = busy_q;

  always_comb begin
    case (io_len)
      2'd0:    be_n = 4'b0001 << io_addr[1:0];
      2'd1:    be_n = 4'b0011 << io_addr[1:0];
      default: be_n = 4'b1111;
    endcase
  end

  assign rd_shift = cfg_rdata >> {off_q, 3'b000};

  always_comb begin
    case (len_q)
      2'd0:    rd_masked = {24'h0, rd_shift[7:0]};
      2'd1:    rd_masked = {16'h0, rd_shift[15:0]};
      default: rd_masked = rd_shift;
    endcase
  end

  assign io_rdata = busy_q  ? rd_masked :
                    en_hit  ? {24'h0, en_q} :
                    fwd_hit ? {24'h0, fwd_q} : 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 8'h00;
      fwd_q     <= 8'h00;
      busy_q    <= 1'b0;
      off_q     <= 2'b00;
      len_q     <= 2'b00;
      cfg_wr    <= 1'b0;
      cfg_bus   <= 8'h00;
      cfg_dev   <= 4'h0;
      cfg_fn    <= 3'h0;
      cfg_dw    <= 6'h00;
      cfg_be    <= 4'h0;
      cfg_wdata <= 32'h0;
    end else begin
      if (local_dn && io_wr && en_hit)  en_q  <= io_wdata[7:0];
      if (local_dn && io_wr && fwd_hit) fwd_q <= io_wdata[7:0];
      if (start) begin
        busy_q    <= 1'b1;
        off_q     <= io_addr[1:0];
        len_q     <= io_len;
        cfg_wr    <= io_wr;
        cfg_bus   <= fwd_q;
        cfg_dev   <= io_addr[11:8];
        cfg_fn    <= en_q[3:1];
        cfg_dw    <= io_addr[7:2];
        cfg_be    <= be_n;
        cfg_wdata <= io_wdata << {io_addr[1:0], 3'b000};
      end else if (busy_q && cfg_ack) begin
        busy_q <= 1'b0;
      end
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_bus) && $stable(cfg_dev) &&
      $stable(cfg_fn) && $stable(cfg_dw) && $stable(cfg_be) && $stable(cfg_wdata)));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |-> !io_ready);

  // R3
  key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> ($past(en_q[7:4]) == KEY));

  // R5
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 ||
                 cfg_be == 4'b1100 || cfg_be == 4'b1111));

  // R8
  unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !cfg_req && !map_on) |-> (io_ready && $stable(busy_q) == $stable(busy_q)) |=> !cfg_req);

  // R9
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_ready && io_wr && en_hit && io_wdata[7:0] == 8'h00) |=> (en_q == 8'h00 && !map_on));

endmodule

// File: tb/cfg2_window_decoder_test.sv
module cfg2_window_decoder_test;
  logic clk = 0, rst_n = 0;
  logic io_req = 0, io_wr = 0, cfg_ack = 0;
  logic [15:0] io_addr = 0;
  logic [1:0] io_len = 0;
  logic [31:0] io_wdata = 0, cfg_rdata = 0;
  logic io_ready, cfg_req, cfg_wr;
  logic [31:0] io_rdata, cfg_wdata;
  logic [7:0] cfg_bus;
  logic [3:0] cfg_dev, cfg_be;
  logic [2:0] cfg_fn;
  logic [5:0] cfg_dw;

  int errs = 0, checks = 0;
  bit exp_busy = 0;
  logic [7:0] m_en = 0, m_fwd = 0;
  logic [31:0] mem [int];

  always #5 clk = ~clk;

  cfg2_window_decoder uut (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) chk("R7 cfg_req every cycle", cfg_req, exp_busy);
  end

  function automatic int mkey(logic [7:0] b, logic [3:0] d, logic [2:0] f, logic [5:0] w);
    return int'({b, d, f, w});
  endfunction

  task automatic io(input logic wr, input logic [15:0] a, input logic [1:0] len,
                    input logic [31:0] wd, input string r);
    bit al, mapped;
    logic [3:0] be;
    logic [31:0] mv, exp_rd, wl;
    int k, sh;
    al = (len == 0) || (len == 1 && !a[0]) || (len == 2 && a[1:0] == 0);
    mapped = (m_en[7:4] == 4'hF) && (a[15:12] == 4'hC) && al;
    sh = 8 * a[1:0];
    be = (len == 0) ? (4'b0001 << a[1:0]) : (len == 1) ? (4'b0011 << a[1:0]) : 4'b1111;
    @(negedge clk);
    io_req = 1; io_wr = wr; io_addr = a; io_len = len; io_wdata = wd;
    #1;
    if (!mapped) begin
      chk({r, " ready same cycle"}, io_ready, 1);
      if (!wr) begin
        if (a == 16'h0CF8 && len == 0) exp_rd = {24'h0, m_en};
        else if (a == 16'h0CFA && len == 0) exp_rd = {24'h0, m_fwd};
        else exp_rd = 32'hFFFF_FFFF;
        chk({r, " rdata"}, io_rdata, exp_rd);
      end else begin
        if (a == 16'h0CF8 && len == 0) m_en = wd[7:0];
        if (a == 16'h0CFA && len == 0) m_fwd = wd[7:0];
      end
      @(negedge clk);
      io_req = 0;
    end else begin
      chk({r, " not ready at issue"}, io_ready, 0);
      @(negedge clk);
      exp_busy = 1;
      #1;
      k = mkey(m_fwd, a[11:8], m_en[3:1], a[7:2]);
      chk({r, " R4 bus"}, cfg_bus, m_fwd);
      chk({r, " R4 dev"}, cfg_dev, a[11:8]);
      chk({r, " R4 fn"}, cfg_fn, m_en[3:1]);
      chk({r, " R4 dw"}, cfg_dw, a[7:2]);
      chk({r, " R5 be"}, cfg_be, be);
      chk({r, " wr"}, cfg_wr, wr);
      if (wr) chk({r, " R5 wdata"}, cfg_wdata, wd << sh);
      chk({r, " R7 stall"}, io_ready, 0);
      @(negedge clk);
      chk({r, " R7 still stalled"}, io_ready, 0);
      mv = mem.exists(k) ? mem[k] : (32'h6C00_0000 | k);
      cfg_ack = 1; cfg_rdata = mv;
      #1;
      chk({r, " R7 ready on ack"}, io_ready, 1);
      if (!wr) begin
        exp_rd = mv >> sh;
        if (len == 0) exp_rd &= 32'hFF;
        if (len == 1) exp_rd &= 32'hFFFF;
        chk({r, " R6 rdata"}, io_rdata, exp_rd);
      end else begin
        wl = wd << sh;
        for (int i = 0; i < 4; i++) if (be[i]) mv[8*i +: 8] = wl[8*i +: 8];
        mem[k] = mv;
      end
      @(negedge clk);
      io_req = 0; cfg_ack = 0; exp_busy = 0;
    end
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    io(0, 16'h0CF8, 0, 0, "R1 enable reset");
    io(0, 16'h0CFA, 0, 0, "R1 forward reset");
    io(0, 16'hC100, 2, 0, "R8 key off read");
    io(1, 16'hC100, 2, 32'h1111_2222, "R8 key off write");
    io(1, 16'h0CF8, 0, 32'hF4, "R2 write enable");
    io(1, 16'h0CFA, 0, 32'h03, "R2 write forward");
    io(0, 16'h0CF8, 0, 0, "R2 read enable");
    io(0, 16'h0CFA, 0, 0, "R2 read forward");
    io(0, 16'hC100, 2, 0, "R8 key-off write had no effect");
    io(1, 16'hC310, 2, 32'hDEAD_BEEF, "R3 dword write");
    io(0, 16'hC310, 2, 0, "R6 dword read");
    io(0, 16'hC312, 0, 0, "R6 byte read lane2");
    io(0, 16'hC312, 1, 0, "R6 word read upper");
    io(1, 16'hC311, 0, 32'h77, "R5 byte write lane1");
    io(0, 16'hC310, 2, 0, "R5 merged read");
    io(0, 16'hC301, 1, 0, "R8 misaligned word");
    io(0, 16'hC302, 2, 0, "R8 misaligned dword");
    io(0, 16'hC300, 3, 0, "R8 size code 3");
    io(0, 16'h0CF9, 0, 0, "R8 other port");
    io(0, 16'h0CF8, 1, 0, "R8 wide access to enable port");
    io(1, 16'hCFFC, 2, 32'h0102_0304, "R4 device 15 last dword");
    io(0, 16'hCFFE, 1, 0, "R4 device 15 word read");
    io(1, 16'h0CF8, 0, 32'hF1, "R2 bit0 set fn0");
    io(0, 16'h0CF8, 0, 0, "R2 bit0 readback");
    io(0, 16'hC310, 2, 0, "R2 bit0 no decode effect");
    io(1, 16'h0CF8, 0, 32'hEE, "R3 wrong key");
    io(0, 16'hC310, 2, 0, "R3 wrong key unmapped");
    io(1, 16'h0CF8, 0, 32'hFE, "R3 key back fn7");
    io(0, 16'hC000, 0, 0, "R3 window base");
    io(1, 16'h0CF8, 0, 32'h00, "R9 zero enable");
    io(1, 16'h0CFA, 0, 32'h00, "R9 zero forward");
    io(0, 16'h0CF8, 0, 0, "R9 enable reads zero");
    io(0, 16'h0CFA, 0, 0, "R9 forward reads zero");
    io(0, 16'hC310, 2, 0, "R9 window off");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule